// File: doc/BRIEF.md
# Serial Two-Wire Register Access Slave

This block lets an external I2C master reach a small byte-wide register bank. It oversamples the open-drain SCL and SDA lines with the system clock. It finds START and STOP conditions and checks the identification byte against a device code and three strap inputs. It then takes a register address and moves data bytes between the bus and the bank. A pointer advances after every byte and wraps from the last address back to zero.

A write is sent as START, the identification byte with the direction bit clear, the address byte, one or more data bytes, and STOP. A read sets the pointer with a write that carries no data bytes. The master then sends a repeated START and the identification byte with the direction bit set. The slave sends bytes for as long as the master acknowledges them. A NACK and then a STOP end the read.

The bank side is a plain strobe port with no back-pressure. A write strobe lasts exactly one cycle and cannot be stalled, so the bank must accept it in that cycle. A read request also lasts one cycle, and the bank must present the data in the next cycle. At most one byte moves per nine SCL periods. After a STOP that ends a transaction with at least one written byte, the block gives a one-cycle pulse that carries the first address written.

Top module: `i2cs_regport`

## Requirements
- R1: The identification byte is sent MSB first: four bits `1010`, then `strap_i[2]`, `strap_i[1]`, `strap_i[0]`, then the direction bit (1 = read). When it matches, SDA is held low during the ninth clock. When it does not match, SDA stays released for that byte and for every later byte, and no write happens, until the next START.
- R2: An address byte with a value up to 8 is acknowledged and loads the pointer. A larger value is not acknowledged, and the slave ignores the bus until the next START.
- R3: SDA is sampled when SCL rises. `sda_oe_o` changes only while SCL is low.
- R4: Each data byte received in a write is acknowledged. For each such byte, `wr_valid_o` is high for exactly one cycle, with `wr_addr_o` set to the pointer and `wr_data_o` set to the byte.
- R5: The pointer advances by one after each byte written or sent. After address 8 it wraps to 0.
- R6: For each byte to send, the slave raises `rd_req_o` for one cycle with `rd_addr_o` set to the pointer. It samples `rd_data_i` in the next cycle and sends that byte MSB first.
- R7: A master ACK (SDA low on the ninth clock) makes the slave fetch and send the next byte. A master NACK leaves SDA released until the next START or STOP.
- R8: A repeated START begins a new identification byte without a STOP, and the pointer keeps its value.
- R9: A STOP after at least one written data byte gives `stop_wr_o` high for one cycle, with `stop_addr_o` set to the first address written since the previous STOP. A STOP after a transaction with no written data byte gives no pulse.
- R10: During reset and just after it, SDA is released and no strobe or pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 3 | Low three bits of the device identity |
| wr_valid_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 4 | Write register address |
| wr_data_o | output | 8 | Write data |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | 4 | Read register address |
| rd_data_i | input | 8 | Read data, valid the cycle after `rd_req_o` |
| stop_wr_o | output | 1 | One-cycle pulse at STOP after a write |
| stop_addr_o | output | 4 | First address written in that transaction |

## Verification
The hardest case to reach is a read that crosses the wrap point and is then cut short by the master. To set it up, the stimulus sends a write with no data bytes that leaves the pointer at the last address. A repeated START and a read identification byte follow. The master acknowledges two bytes and NACKs the third, so the sequence runs from address 8 to 0 to 1. The master then clocks one more byte before the STOP, to show that the slave keeps SDA released after the NACK.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } i2cs_state_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edge while SCL stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2cs_ptr.sv
module i2cs_ptr #(
  parameter int AW        = 4,
  parameter int LAST_ADDR = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LASTP = AW'(LAST_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (step_i) ptr_o <= (ptr_o == LASTP) ? '0 : ptr_o + 1'b1;
  end

  // R5: wrap from the last address to zero
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && ptr_o == LASTP) |=> (ptr_o == '0));
  // R5: plain increment below the last address
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && ptr_o != LASTP) |=> (ptr_o == $past(ptr_o) + 1'b1));
endmodule

// File: rtl/i2cs_regport.sv
module i2cs_regport
  import i2cs_pkg::*;
#(
  parameter int          AW          = 4,
  parameter int          LAST_ADDR   = 8,
  parameter logic [3:0]  DEV_CODE    = 4'b1010,
  parameter int          SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [2:0]    strap_i,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          stop_wr_o,
  output logic [AW-1:0] stop_addr_o
);
  localparam logic [7:0] LAST8   = 8'(LAST_ADDR);
  localparam logic [3:0] BIT_END = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_c), .stop_o(stop_c)
  );

  i2cs_state_t   st;
  logic [3:0]    cnt;
  logic          ack_ph, go, wrote, load_now;
  logic [7:0]    rx, tx;
  logic [AW-1:0] first_addr, ptr;

  logic rcv, active, byte_end, id_ok, addr_ok, ptr_load, ptr_step;

  assign rcv      = (st == ST_ID) || (st == ST_ADDR) || (st == ST_WDATA);
  assign active   = rcv || (st == ST_RDATA);
  assign byte_end = scl_fall && !ack_ph && (cnt == BIT_END) && active;
  assign id_ok    = (rx[7:1] == {DEV_CODE, strap_i});
  assign addr_ok  = (rx <= LAST8);
  assign ptr_load = byte_end && (st == ST_ADDR) && addr_ok && !start_c && !stop_c;
  assign ptr_step = byte_end && ((st == ST_WDATA) || (st == ST_RDATA)) && !start_c && !stop_c;

  i2cs_ptr #(.AW(AW), .LAST_ADDR(LAST_ADDR)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(ptr_load), .load_val_i(rx[AW-1:0]),
    .step_i(ptr_step), .ptr_o(ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; ack_ph <= 1'b0; go <= 1'b0; wrote <= 1'b0;
      load_now <= 1'b0; rx <= '0; tx <= '0; sda_oe_o <= 1'b0; first_addr <= '0;
      wr_valid_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
      rd_req_o <= 1'b0; rd_addr_o <= '0; stop_wr_o <= 1'b0; stop_addr_o <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      rd_req_o   <= 1'b0;
      stop_wr_o  <= 1'b0;
      load_now   <= rd_req_o;
      if (start_c) begin
        st <= ST_ID; cnt <= '0; ack_ph <= 1'b0; sda_oe_o <= 1'b0; load_now <= 1'b0;
      end else if (stop_c) begin
        st <= ST_IDLE; cnt <= '0; ack_ph <= 1'b0; sda_oe_o <= 1'b0; load_now <= 1'b0;
        stop_wr_o   <= wrote;
        stop_addr_o <= first_addr;
        wrote       <= 1'b0;
      end else begin
        // fetched byte arrives one cycle after the request
        if (load_now && st == ST_RDATA) begin
          tx       <= rd_data_i;
          sda_oe_o <= ~rd_data_i[7];
        end
        if (scl_rise && !ack_ph && active) begin
          cnt <= cnt + 4'd1;
          if (rcv) rx <= {rx[6:0], sda_s};
        end
        if (scl_rise && ack_ph && st == ST_RDATA) go <= ~sda_s;
        if (scl_fall && !ack_ph && st == ST_RDATA && cnt != 4'd0 && cnt != BIT_END) begin
          tx       <= {tx[6:0], 1'b0};
          sda_oe_o <= ~tx[6];
        end
        if (byte_end) begin
          cnt    <= '0;
          ack_ph <= 1'b1;
          unique case (st)
            ST_ID: begin
              if (id_ok) begin
                sda_oe_o <= 1'b1;
                go       <= 1'b1;
                st       <= rx[0] ? ST_RDATA : ST_ADDR;
              end else begin
                st     <= ST_SKIP;
                ack_ph <= 1'b0;
              end
            end
            ST_ADDR: begin
              if (addr_ok) begin
                sda_oe_o <= 1'b1;
                st       <= ST_WDATA;
                if (!wrote) first_addr <= rx[AW-1:0];
              end else begin
                st     <= ST_SKIP;
                ack_ph <= 1'b0;
              end
            end
            ST_WDATA: begin
              sda_oe_o   <= 1'b1;
              wrote      <= 1'b1;
              wr_valid_o <= 1'b1;
              wr_addr_o  <= ptr;
              wr_data_o  <= rx;
            end
            default: sda_oe_o <= 1'b0;  // ST_RDATA: free SDA for master ack
          endcase
        end
        if (scl_fall && ack_ph) begin
          ack_ph   <= 1'b0;
          sda_oe_o <= 1'b0;
          if (st == ST_RDATA) begin
            if (go) begin
              rd_req_o  <= 1'b1;
              rd_addr_o <= ptr;
            end else begin
              st <= ST_SKIP;
            end
          end
        end
      end
    end
  end

  // R1, R2: an ignored transaction never pulls SDA
  a_r1_skip_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> !sda_oe_o);
  // R3: drive changes only while SCL is low
  a_r3_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));
  // R4: write strobe lasts one cycle
  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);
  // R6: read request lasts one cycle
  a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);
  // R9: stop pulse lasts one cycle
  a_r9_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr_o |=> !stop_wr_o);
  // R8: START always restarts identification with SDA released
  a_r8_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (!sda_oe_o && st == ST_ID));
endmodule

// File: tb/tb_i2cs_regport.sv
module tb_i2cs_regport;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam int H = 20;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_valid, rd_req, stop_wr;
  logic [3:0] wr_addr, rd_addr, stop_addr;
  logic [7:0] wr_data, rd_data;
  wire sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cs_regport dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(STRAP), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .stop_wr_o(stop_wr), .stop_addr_o(stop_addr)
  );

  int n_chk = 0, n_fail = 0, stop_cnt = 0;
  bit done = 0;
  logic [7:0] bank [0:8];
  logic [7:0] exp_mem [0:8];
  logic [11:0] wq[$];
  bit exp_stop = 0;
  logic [3:0] exp_stop_addr = '0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // register bank behind the slave
  initial for (int i = 0; i < 9; i++) begin
    bank[i] = 8'(i * 17 + 3);
    exp_mem[i] = 8'(i * 17 + 3);
  end
  always @(posedge clk) begin
    if (wr_valid && wr_addr <= 4'd8) bank[wr_addr] <= wr_data;
    if (rd_req) rd_data <= (rd_addr <= 4'd8) ? bank[rd_addr] : 8'h00;
  end

  // per-clock comparison against the expected-event model
  always @(negedge clk) if (rst_n) begin
    if (wr_valid) begin
      if (wq.size() == 0) chk("R4 unexpected write strobe", 1, 0);
      else begin
        logic [11:0] e;
        e = wq.pop_front();
        chk("R4 R5 write addr/data", {wr_addr, wr_data}, e);
      end
    end
    if (stop_wr) begin
      stop_cnt++;
      chk("R9 stop pulse expected", exp_stop, 1);
      chk("R9 stop address", stop_addr, exp_stop_addr);
      exp_stop = 0;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ackbit);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1; tick(H); scl_m = 0; tick(Q);
    end
    sda_m = 1; tick(Q); scl_m = 1; tick(H/2); ackbit = sda_bus; tick(H/2);
    scl_m = 0; tick(Q);
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] v);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl_m = 1; tick(H/2); v = {v[6:0], sda_bus}; tick(H/2);
      scl_m = 0; tick(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(Q); scl_m = 1; tick(H); scl_m = 0; tick(Q);
    sda_m = 1;
  endtask

  function automatic logic [7:0] idb(input logic [2:0] s, input bit rd);
    return {4'b1010, s, rd};
  endfunction

  task automatic write_burst(input logic [3:0] a, input logic [7:0] d0, input int n);
    logic ak;
    logic [3:0] p;
    i2c_start();
    wbyte(idb(STRAP, 0), ak); chk("R1 id ack", ak, 0);
    wbyte({4'h0, a}, ak);     chk("R2 addr ack", ak, 0);
    p = a;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = d0 + 8'(k * 16);
      wq.push_back({p, d});
      exp_mem[p] = d;
      wbyte(d, ak); chk("R4 data ack", ak, 0);
      p = (p == 4'd8) ? 4'd0 : p + 4'd1;
    end
    exp_stop = 1; exp_stop_addr = a;
    i2c_stop(); tick(10);
    chk("R9 stop pulse seen", exp_stop, 0);
  endtask

  initial begin
    logic ak;
    logic [7:0] v;
    int sc;
    tick(3);
    chk("R10 reset sda released", sda_oe, 0);
    chk("R10 reset no write", wr_valid, 0);
    chk("R10 reset no stop pulse", stop_wr, 0);
    rst_n = 1; tick(5);
    chk("R10 idle after reset", {sda_oe, wr_valid, rd_req, stop_wr}, 0);

    // plain two-byte write
    write_burst(4'd2, 8'h55, 2);
    // write across the wrap point: 7, 8, 0
    write_burst(4'd7, 8'hA1, 3);

    // dummy write, repeated START, read 8 -> 0 -> 1 with NACK on the last
    sc = stop_cnt;
    i2c_start();
    wbyte(idb(STRAP, 0), ak); chk("R1 id ack before read", ak, 0);
    wbyte(8'h08, ak);         chk("R2 addr 8 ack", ak, 0);
    i2c_start();
    wbyte(idb(STRAP, 1), ak); chk("R8 id ack after repeated start", ak, 0);
    rbyte(1, v); chk("R6 R3 read byte at 8", v, exp_mem[8]);
    rbyte(1, v); chk("R5 R7 read byte after wrap", v, exp_mem[0]);
    rbyte(0, v); chk("R6 read byte at 1", v, exp_mem[1]);
    rbyte(0, v); chk("R7 released after master nack", v, 8'hFF);
    i2c_stop(); tick(10);
    chk("R9 no pulse after read", stop_cnt, sc);

    // wrong strap: no ack, no write
    i2c_start();
    wbyte(idb(STRAP ^ 3'b001, 0), ak); chk("R1 mismatch nack", ak, 1);
    wbyte(8'h03, ak); chk("R1 ignored address byte", ak, 1);
    wbyte(8'h99, ak); chk("R1 ignored data byte", ak, 1);
    i2c_stop(); tick(10);
    chk("R1 no pulse after ignored write", stop_cnt, sc);

    // out-of-range address
    i2c_start();
    wbyte(idb(STRAP, 0), ak); chk("R1 id ack", ak, 0);
    wbyte(8'h09, ak); chk("R2 addr 9 nack", ak, 1);
    wbyte(8'h77, ak); chk("R2 data after bad addr ignored", ak, 1);
    i2c_stop(); tick(10);
    chk("R2 no pulse after bad addr", stop_cnt, sc);

    // read straight after START: pointer kept from the read above (now 2)
    i2c_start();
    wbyte(idb(STRAP, 1), ak); chk("R8 read id ack", ak, 0);
    rbyte(0, v); chk("R5 R6 pointer retained", v, exp_mem[2]);
    i2c_stop(); tick(10);

    chk("R4 all writes seen", wq.size(), 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    finish_run();
  end
endmodule